// File: doc/BRIEF.md
# Width-Adaptive Query and Identifier Read Responder

This block answers the two special read modes of a parallel flash bank: reads of the standard query table and reads of the manufacturer and part identifiers. The bank may be built from one or several flash devices side by side. A device may also be a wide part that is strapped to run in byte mode. The caller supplies the byte offset of the read, the access width, and three width settings, each as a log2 of a byte count: the bank width, the device width, and the widest mode the device supports. The block works out which table entry each device would see, fetches that byte or identifier, and widens it for byte-mode parts. It then copies the result into every device slot of the bank and, when the access is wider than the bank, joins several bank words together.

The answer is registered and appears on `rsp_data`, with `rsp_valid` high, exactly one clock after `rd_en`. Between reads the last answer is held. Command decoding and the array contents belong to neighbouring logic.

Top module: `cfiq_responder`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `rd_en` high and low otherwise. `rsp_data` carries that read's answer and keeps it, unchanged by any input, until the next read.
- R2: For a read at lane offset `o`, the per-device index is `o >> (bank_lg + maxdev_lg - dev_lg)`. Offset bits below that shift have no effect.
- R3: Query reads (`rd_kind` = 0) return the fixed table. Entries 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59 (ASCII Q R Y). Entries 0x13 and 0x14 hold 0x01 and 0x00. Entry 0x15 holds 0x31. Entries 0x31, 0x32 and 0x33 hold 0x50, 0x52 and 0x49 (ASCII P R I). Entry 0x2A holds 8 when `bank_lg` = 0 and 11 otherwise. Every other entry below 0x52 reads 0.
- R4: A query index of 0x52 or above reads as 0.
- R5: When `dev_lg` < `maxdev_lg` and `dev_lg` = 0 (a wide part in byte mode), every byte of the device answer equals the table byte. When `dev_lg` < `maxdev_lg` and `dev_lg` > 0, a query returns 0.
- R6: Otherwise the device answer for a query is the table byte in the device's lowest byte, with zeros above it. Byte b of a bank word is byte (b mod device width) of the device answer, so each device slot carries a copy.
- R7: Identifier reads (`rd_kind` = 1) use only index bits [7:0]. Index 0 gives `mfr_code` and index 1 gives `part_code`; both are 16 bits, truncated to the device width or zero-extended above it. Any other index gives 0. The result is replicated per device slot as in R6.
- R8: When the access is wider than the bank, bank word k fills access bytes [k*bank, k*bank+bank-1] and is answered for offset `rd_offset + k*bank` (modulo 2^ADDR_W). The lowest offset sits in the least significant bytes.
- R9: Bytes of `rsp_data` at and above the access width (2^`acc_lg` bytes) are 0. When the access is narrower than the bank, the low bytes of the bank word are returned.
- R10: While `rst` is high, and after it falls until the first read, `rsp_valid` and `rsp_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_kind | input | 1 | 0 = query table, 1 = identifier |
| rd_offset | input | ADDR_W | Byte offset of the read |
| acc_lg | input | 2 | log2 of the access width in bytes (0..2) |
| bank_lg | input | 2 | log2 of the bank width in bytes (0..2) |
| dev_lg | input | 2 | log2 of the device width, at most bank_lg and maxdev_lg |
| maxdev_lg | input | 2 | log2 of the widest device mode (0..2) |
| mfr_code | input | 16 | Manufacturer identifier |
| part_code | input | 16 | Part identifier |
| rsp_valid | output | 1 | Answer valid, one cycle after rd_en |
| rsp_data | output | DATA_W | Registered answer |

## Verification
The bench builds the block with its default parameters: a 16-bit offset and a 32-bit data path, which allows bank and access widths of 1, 2 and 4 bytes. Because the widths are ports, one build sweeps every legal combination of bank, device and maximum-device width. It uses all three access widths and both read kinds. The chosen indices sit on the named table entries, on both sides of the 0x52 limit, and above 0xFF for the identifier mask. This covers byte-mode widening, unsupported narrow modes, zero padding of native wide devices and multi-word concatenation.

// File: rtl/cfiq_pkg.sv
package cfiq_pkg;
  localparam int unsigned TBL_LEN    = 'h52;
  localparam logic [7:0]  BUF_NARROW = 8'd8;
  localparam logic [7:0]  BUF_WIDE   = 8'd11;
  localparam logic        KIND_QUERY = 1'b0;
  localparam logic        KIND_IDENT = 1'b1;

  // Fixed query table; entries not listed read zero.
  function automatic logic [7:0] qtable(input logic [6:0] idx, input logic wide_bank);
    logic [7:0] v;
    case (idx)
      7'h10:   v = 8'h51;
      7'h11:   v = 8'h52;
      7'h12:   v = 8'h59;
      7'h13:   v = 8'h01;
      7'h14:   v = 8'h00;
      7'h15:   v = 8'h31;
      7'h2A:   v = wide_bank ? BUF_WIDE : BUF_NARROW;
      7'h31:   v = 8'h50;
      7'h32:   v = 8'h52;
      7'h33:   v = 8'h49;
      default: v = 8'h00;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/cfiq_dev_resp.sv
module cfiq_dev_resp
  import cfiq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LG_W   = 2
) (
  input  logic              kind,
  input  logic [ADDR_W-1:0] idx,
  input  logic [LG_W-1:0]   dev_lg,
  input  logic [LG_W-1:0]   maxdev_lg,
  input  logic              wide_bank,
  input  logic [15:0]       mfr_code,
  input  logic [15:0]       part_code,
  output logic [DATA_W-1:0] dev_word
);
  localparam int BYTES = DATA_W / 8;

  logic       in_range;
  logic [7:0] tbl_byte;
  logic [7:0] id_sel;
  logic [15:0] id_word;

  assign in_range = (idx < ADDR_W'(TBL_LEN));
  assign tbl_byte = in_range ? qtable(idx[6:0], wide_bank) : 8'h00;
  assign id_sel   = idx[7:0];

  always_comb begin
    if (id_sel == 8'd0)      id_word = mfr_code;
    else if (id_sel == 8'd1) id_word = part_code;
    else                     id_word = 16'h0000;
  end

  always_comb begin
    dev_word = '0;
    if (kind == KIND_IDENT) begin
      dev_word[15:0] = id_word;
    end else if (dev_lg < maxdev_lg) begin
      // wide part strapped narrow: only byte mode answers, byte repeated
      if (dev_lg == '0) begin
        for (int b = 0; b < BYTES; b++) dev_word[8*b +: 8] = tbl_byte;
      end
    end else begin
      dev_word[7:0] = tbl_byte;
    end
  end
endmodule

// File: rtl/cfiq_lane.sv
module cfiq_lane
  import cfiq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LG_W   = 2,
  parameter int LANE   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kind,
  input  logic [ADDR_W-1:0] offset,
  input  logic [LG_W-1:0]   bank_lg,
  input  logic [LG_W-1:0]   dev_lg,
  input  logic [LG_W-1:0]   maxdev_lg,
  input  logic [15:0]       mfr_code,
  input  logic [15:0]       part_code,
  output logic [DATA_W-1:0] bank_word
);
  localparam int BYTES = DATA_W / 8;
  localparam int SH_W  = LG_W + 1;

  logic [ADDR_W-1:0] lane_off;
  logic [SH_W-1:0]   shamt;
  logic [ADDR_W-1:0] lane_idx;
  logic [DATA_W-1:0] dev_word;
  logic              wide_bank;

  assign lane_off  = offset + (ADDR_W'(LANE) << bank_lg);
  assign shamt     = {1'b0, bank_lg} + {1'b0, maxdev_lg} - {1'b0, dev_lg};
  assign lane_idx  = lane_off >> shamt;
  assign wide_bank = (bank_lg != '0);

  cfiq_dev_resp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LG_W  (LG_W)
  ) u_dev (
    .kind     (kind),
    .idx      (lane_idx),
    .dev_lg   (dev_lg),
    .maxdev_lg(maxdev_lg),
    .wide_bank(wide_bank),
    .mfr_code (mfr_code),
    .part_code(part_code),
    .dev_word (dev_word)
  );

  // copy the device answer into every device slot of the bank
  always_comb begin
    bank_word = '0;
    for (int b = 0; b < BYTES; b++) begin
      int s;
      s = b & ((1 << dev_lg) - 1);
      bank_word[8*b +: 8] = dev_word[8*s +: 8];
    end
  end

  AST_QUERY_RANGE: assert property (@(posedge clk) disable iff (rst)
    (kind == KIND_QUERY && lane_idx >= ADDR_W'(TBL_LEN)) |-> dev_word == '0); // R4
  AST_IDENT_MASK: assert property (@(posedge clk) disable iff (rst)
    (kind == KIND_IDENT && lane_idx[7:0] > 8'd1) |-> dev_word == '0); // R7
endmodule

// File: rtl/cfiq_responder.sv
module cfiq_responder
  import cfiq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_kind,
  input  logic [ADDR_W-1:0] rd_offset,
  input  logic [1:0]        acc_lg,
  input  logic [1:0]        bank_lg,
  input  logic [1:0]        dev_lg,
  input  logic [1:0]        maxdev_lg,
  input  logic [15:0]       mfr_code,
  input  logic [15:0]       part_code,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int BYTES = DATA_W / 8;
  localparam int LG_W  = 2;

  logic [DATA_W-1:0] lane_word [BYTES];
  logic [DATA_W-1:0] rsp_nxt;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    cfiq_lane #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .LG_W  (LG_W),
      .LANE  (g)
    ) u_lane (
      .clk      (clk),
      .rst      (rst),
      .kind     (rd_kind),
      .offset   (rd_offset),
      .bank_lg  (bank_lg),
      .dev_lg   (dev_lg),
      .maxdev_lg(maxdev_lg),
      .mfr_code (mfr_code),
      .part_code(part_code),
      .bank_word(lane_word[g])
    );
  end

  // assemble the access from successive bank words, mask above access width
  always_comb begin
    rsp_nxt = '0;
    for (int j = 0; j < BYTES; j++) begin
      int ln;
      int bi;
      ln = j >> bank_lg;
      bi = j & ((1 << bank_lg) - 1);
      if (j < (1 << acc_lg)) rsp_nxt[8*j +: 8] = lane_word[ln][8*bi +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rsp_nxt;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rsp_valid); // R1
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rsp_valid); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rsp_data)); // R1
  AST_NARROW_MASK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && acc_lg == 2'd0) |=> rsp_data[DATA_W-1:8] == '0); // R9
  AST_UNSUP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_kind == KIND_QUERY && dev_lg != 2'd0 && dev_lg < maxdev_lg)
      |=> rsp_data == '0); // R5
endmodule

// File: tb/cfiq_responder_bench.sv
`timescale 1ns/1ps
module cfiq_responder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        rd_kind = 1'b0;
  logic [15:0] rd_offset = '0;
  logic [1:0]  acc_lg = '0, bank_lg = '0, dev_lg = '0, maxdev_lg = '0;
  logic [15:0] mfr_code = '0, part_code = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  logic        exp_valid = 1'b0;
  logic [31:0] exp_data  = '0;

  always #10 clk = ~clk;

  cfiq_responder u_cfiq_responder (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_kind(rd_kind), .rd_offset(rd_offset),
    .acc_lg(acc_lg), .bank_lg(bank_lg), .dev_lg(dev_lg), .maxdev_lg(maxdev_lg),
    .mfr_code(mfr_code), .part_code(part_code),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic int tbl(int i, int bl);
    if (i == 'h2A) return (bl == 0) ? 8 : 11;
    if (i == 'h10) return 'h51;
    if (i == 'h11) return 'h52;
    if (i == 'h12) return 'h59;
    if (i == 'h13) return 1;
    if (i == 'h15) return 'h31;
    if (i == 'h31) return 'h50;
    if (i == 'h32) return 'h52;
    if (i == 'h33) return 'h49;
    return 0;
  endfunction

  function automatic logic [31:0] model(int kind, int off, int acc, int bl, int dl, int ml,
                                        int mfr, int pc);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < (1 << acc); j++) begin
      int lo;
      int idx;
      int db;
      int v;
      lo  = (off + ((j >> bl) << bl)) % 65536;
      idx = lo >> (bl + ml - dl);
      db  = (j % (1 << bl)) % (1 << dl);
      v   = 0;
      if (kind == 0) begin
        int t;
        t = (idx >= 'h52) ? 0 : tbl(idx, bl);
        if (dl < ml) v = (dl == 0) ? t : 0;
        else         v = (db == 0) ? t : 0;
      end else begin
        int c;
        c = ((idx % 256) == 0) ? mfr : (((idx % 256) == 1) ? pc : 0);
        v = (db == 0) ? (c % 256) : ((db == 1) ? (c / 256) : 0);
      end
      r[8*j +: 8] = v[7:0];
    end
    return r;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (rsp_valid !== exp_valid) begin
      fails++;
      $display("FAIL %s valid: actual %0b expected %0b", tag, rsp_valid, exp_valid);
    end
    checks++;
    if (rsp_data !== exp_data) begin
      fails++;
      $display("FAIL %s data: actual %08h expected %08h (kind %0d off %04h acc %0d bank %0d dev %0d max %0d)",
               tag, rsp_data, exp_data, rd_kind, rd_offset, acc_lg, bank_lg, dev_lg, maxdev_lg);
    end
  endtask

  // one clock: drive at negedge, compare at the next negedge
  task automatic step(bit en, int kind, int off, int acc, string tag);
    rd_en     = en;
    rd_kind   = kind[0];
    rd_offset = off[15:0];
    acc_lg    = acc[1:0];
    exp_valid = en;
    if (en) exp_data = model(kind, off, acc, bank_lg, dev_lg, maxdev_lg, mfr_code, part_code);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int qidx[18] = '{'h10, 'h11, 'h12, 'h13, 'h14, 'h15, 'h2A, 'h31, 'h32, 'h33,
                     0, 1, 2, 'h51, 'h52, 'h53, 'h7F, 'h100};
    int cfg = 0;
    repeat (2) @(negedge clk);
    compare("R10");
    rst = 1'b0;
    @(negedge clk);
    compare("R10");
    for (int bl = 0; bl <= 2; bl++) begin
      for (int dl = 0; dl <= bl; dl++) begin
        for (int ml = dl; ml <= 2; ml++) begin
          int sh;
          bank_lg   = bl[1:0];
          dev_lg    = dl[1:0];
          maxdev_lg = ml[1:0];
          mfr_code  = 16'h0089 ^ 16'(cfg * 'h111);
          part_code = 16'h8A17 + 16'(cfg);
          cfg++;
          sh = bl + ml - dl;
          for (int acc = 0; acc <= 2; acc++) begin
            for (int kind = 0; kind <= 1; kind++) begin
              foreach (qidx[q]) begin
                string tag;
                int off;
                off = qidx[q] << sh;
                if (kind == 1)        tag = "R7";
                else if (acc > bl)    tag = "R8";
                else if (acc < bl)    tag = "R9";
                else if (qidx[q] >= 'h52) tag = "R4";
                else if (dl < ml)     tag = "R5";
                else if (bl > dl)     tag = "R6";
                else                  tag = "R3";
                step(1'b1, kind, off, acc, tag);
                step(1'b0, 1 - kind, off ^ 16'h5A5A, 2 - acc, "R1");
                if (sh > 0) step(1'b1, kind, off + ((1 << sh) - 1), acc, "R2");
              end
            end
          end
        end
      end
    end
    step(1'b1, 0, 'h10, 2, "R1");
    step(1'b1, 1, 0, 2, "R1");
    step(1'b0, 0, 0, 0, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule